// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This peripheral sits on a simple processor register bus and drives a four-wire serial link as the clocking master. Software sets an enable bit, an interrupt enable bit and a two-bit clock-rate select in a control register. Writing a byte to the data register starts a full-duplex exchange of eight bits. When the exchange ends, the data register holds the byte clocked in from the remote device and a completion flag is raised. That flag can drive an interrupt request.

The serial clock runs at the system clock divided by 4, 16, 64 or 128. The rate is latched when each exchange starts. A data write that arrives while an exchange is still running does not disturb that exchange; it raises a collision flag instead. Both flags are cleared in two steps. Software first reads the status register while a flag is set. The next access of the data register, read or write, then clears that flag. An interrupt acknowledge pulse also clears the completion flag.

Top module: `spi_master_regs`

## Requirements
- R1: After reset the control, status and data registers read 0x00, `irq` is low, `sck` is low and `mosi` is low.
- R2: A data write with the enable bit set starts an exchange lasting 8×D system clocks. D is chosen by control bits 1:0 (00→4, 01→16, 10→64, 11→128) and is sampled at the start, so later control writes do not change the running exchange.
- R3: `sck` is low while idle and has period D. Data leaves MSB first on `mosi`, which changes only on falling `sck`. `miso` is sampled on rising `sck`.
- R4: When an exchange completes, the data register takes the received byte and the completion flag (status bit 7) is set in the same cycle.
- R5: A data write while the enable bit (control bit 6) is clear starts nothing and leaves the data register unchanged.
- R6: A data write during an exchange sets the collision flag (status bit 6). It neither restarts nor alters the running exchange, and the data register keeps its contents.
- R7: A status read marks each flag that is set at that moment. The next data-register read or write clears only the marked flags. A data access with no prior marking leaves the flags set.
- R8: `irq` is high exactly when control bit 7 (interrupt enable), control bit 6 (enable) and the completion flag are all set.
- R9: A one-cycle `irq_ack` pulse clears the completion flag.
- R10: Address 0 is control, with bits 7, 6, 1 and 0 read back and the others reading 0. Address 1 is status, with bits 5:0 reading 0. Address 2 is data. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |

## Verification
A behavioural remote device shifts a chosen byte onto `miso` and records what appears on `mosi`. Exchanges are run with every rate select and with byte pairs that are all zeros, all ones, alternating and single-bit. These pairs separate bit-order errors, off-by-one shift counts and swapped directions. Cycle counts to completion separate the four divisors. A control write mid-exchange shows whether the rate is really latched at the start. Directed sequences cover collision writes, marked versus unmarked flag clears, interrupt gating on each enable and acknowledge, and writes with the enable bit clear.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
    localparam int PC_W = 7;

    // half of the serial clock period, in system clocks
    function automatic logic [PC_W-1:0] half_period(input logic [1:0] sel);
        case (sel)
            2'b00:   return PC_W'(2);
            2'b01:   return PC_W'(8);
            2'b10:   return PC_W'(32);
            default: return PC_W'(64);
        endcase
    endfunction
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_regs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] tx_byte,
    input  logic [1:0]    rate_sel,
    input  logic          miso,
    output logic          busy,
    output logic          sck,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx_byte
);
    localparam int BW = $clog2(DW + 1);

    typedef struct packed {
        logic            busy;
        logic            sck;
        logic [PC_W-1:0] half;
        logic [PC_W-1:0] pc;
        logic [BW-1:0]   bits;
        logic [DW-1:0]   sh;
        logic            rbit;
    } eng_t;

    eng_t st_d, st_q;
    logic done_d;

    always_comb begin
        st_d   = st_q;
        done_d = 1'b0;
        if (st_q.busy) begin
            if (st_q.pc == st_q.half - PC_W'(1)) begin
                st_d.pc  = '0;
                st_d.sck = ~st_q.sck;
                if (!st_q.sck) begin
                    st_d.rbit = miso;                 // rising edge: sample
                end else begin
                    st_d.sh   = {st_q.sh[DW-2:0], st_q.rbit}; // falling edge: shift
                    st_d.bits = st_q.bits - BW'(1);
                    if (st_q.bits == BW'(1)) begin
                        st_d.busy = 1'b0;
                        done_d    = 1'b1;
                    end
                end
            end else begin
                st_d.pc = st_q.pc + PC_W'(1);
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.sck  = 1'b0;
            st_d.pc   = '0;
            st_d.bits = BW'(DW);
            st_d.sh   = tx_byte;
            st_d.half = half_period(rate_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign sck     = st_q.sck;
    assign mosi    = st_q.busy & st_q.sh[DW-1];
    assign done    = done_d;
    assign rx_byte = {st_q.sh[DW-2:0], st_q.rbit};
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic collide,
    input  logic stat_rd,
    input  logic data_acc,
    input  logic irq_ack,
    output logic spif,
    output logic wcol
);
    typedef struct packed {
        logic spif;
        logic wcol;
        logic mk_spif;
        logic mk_wcol;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_rd) begin
            st_d.mk_spif = st_q.mk_spif | st_q.spif;
            st_d.mk_wcol = st_q.mk_wcol | st_q.wcol;
        end
        if (data_acc) begin
            if (st_q.mk_spif) st_d.spif = 1'b0;
            if (st_q.mk_wcol) st_d.wcol = 1'b0;
            st_d.mk_spif = 1'b0;
            st_d.mk_wcol = 1'b0;
        end
        if (irq_ack) st_d.spif = 1'b0;
        // new events win over a clear in the same cycle
        if (done)    st_d.spif = 1'b1;
        if (collide) st_d.wcol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign spif = st_q.spif;
    assign wcol = st_q.wcol;
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
    import spi_regs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              irq,
    input  logic              irq_ack
);
    typedef struct packed {
        logic          ie;
        logic          en;
        logic [1:0]    rate;
        logic [DW-1:0] data;
    } reg_t;

    reg_t st_d, st_q;

    logic wr_ctrl, rd_stat, wr_data, rd_data;
    logic start, collide, busy, done, spif, wcol;
    logic [DW-1:0] rx_byte;

    assign wr_ctrl = bus_sel & bus_wr & (bus_addr == A_CTRL);
    assign rd_stat = bus_sel & bus_rd & (bus_addr == A_STAT);
    assign wr_data = bus_sel & bus_wr & (bus_addr == A_DATA);
    assign rd_data = bus_sel & bus_rd & (bus_addr == A_DATA);
    assign start   = wr_data & st_q.en & ~busy;
    assign collide = wr_data & st_q.en & busy;

    spi_shift_engine #(.DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(bus_wdata),
        .rate_sel(st_q.rate), .miso(miso), .busy(busy), .sck(sck),
        .mosi(mosi), .done(done), .rx_byte(rx_byte)
    );

    spi_flag_unit u_flags (
        .clk(clk), .rst_n(rst_n), .done(done), .collide(collide),
        .stat_rd(rd_stat), .data_acc(wr_data | rd_data), .irq_ack(irq_ack),
        .spif(spif), .wcol(wcol)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ie   = bus_wdata[7];
            st_d.en   = bus_wdata[6];
            st_d.rate = bus_wdata[1:0];
        end
        if (start) st_d.data = bus_wdata;
        if (done)  st_d.data = rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[7]   = st_q.ie;
                bus_rdata[6]   = st_q.en;
                bus_rdata[1:0] = st_q.rate;
            end
            A_STAT: begin
                bus_rdata[7] = spif;
                bus_rdata[6] = wcol;
            end
            A_DATA:  bus_rdata = st_q.data;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = st_q.ie & st_q.en & spif;
endmodule

// File: rtl/spi_master_regs_chk.sv
module spi_master_regs_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sck,
    input logic mosi,
    input logic done,
    input logic spif,
    input logic wcol,
    input logic irq_ack,
    input logic wr_data,
    input logic en
);
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sck && !mosi));

    assert_done_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> spif);

    assert_disabled_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_data && !en) |=> !busy);

    assert_collide_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && wr_data && en) |=> (wcol && busy));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !done) |=> !spif);
endmodule

bind spi_master_regs spi_master_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sck(sck), .mosi(mosi),
    .done(done), .spif(spif), .wcol(wcol), .irq_ack(irq_ack),
    .wr_data(wr_data), .en(st_q.en)
);

// File: tb/spi_master_regs_bench.sv
module spi_master_regs_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic sck, mosi, miso, irq;
    logic irq_ack = 0;

    always #4 clk = ~clk;   // 125 MHz

    spi_master_regs u_spi_master_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi), .miso(miso),
        .irq(irq), .irq_ack(irq_ack)
    );

    // behavioural remote device
    logic [7:0] slv_val = 0, slv_sh = 0, cap = 0;
    logic slv_load = 0;
    always @(negedge sck or posedge slv_load)
        if (slv_load) slv_sh <= slv_val;
        else          slv_sh <= {slv_sh[6:0], 1'b0};
    always @(posedge sck) cap <= {cap[6:0], mosi};
    assign miso = slv_sh[7];

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 0; bus_rd = 0;
    endtask

    task automatic load_slave(input logic [7:0] v);
        slv_val = v; slv_load = 1; #1 slv_load = 0;
    endtask

    task automatic wait_irq(input int t0, output int len);
        len = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (irq) begin len = cyc - t0; break; end
        end
    endtask

    // {rate select, byte sent, byte returned by remote device}
    localparam logic [17:0] VEC [6] = '{
        {2'b00, 8'hA5, 8'h3C}, {2'b01, 8'h00, 8'hFF}, {2'b10, 8'hFF, 8'h00},
        {2'b11, 8'h81, 8'h7E}, {2'b00, 8'h5A, 8'hC3}, {2'b01, 8'h01, 8'h80}
    };

    initial begin
        for (int w = 0; w < 150000; w++) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] rd, saved;
        int t0, len, div;
        bit sck_seen;
        repeat (3) @(posedge clk);
        // R1 reset values
        check("R1 ctrl", {24'd0, bus_rdata}, 0);
        bus_read(2'd0, rd); check("R1 ctrl", rd, 8'h00);
        bus_read(2'd1, rd); check("R1 status", rd, 8'h00);
        bus_read(2'd2, rd); check("R1 data", rd, 8'h00);
        check("R1 irq/sck/mosi", {irq, sck, mosi}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        check("R1 after release", {irq, sck, mosi}, 0);

        // R10 register map
        bus_write(2'd0, 8'hFF); bus_read(2'd0, rd); check("R10 ctrl readback", rd, 8'hC3);
        bus_read(2'd3, rd); check("R10 addr3", rd, 8'h00);

        // R2 R3 R4 R7 R8: vector table
        foreach (VEC[k]) begin
            div = 4 << (2 * VEC[k][17:16]);
            if (VEC[k][17:16] == 2'b11) div = 128;
            bus_write(2'd0, {6'b110000, VEC[k][17:16]});
            load_slave(VEC[k][7:0]);
            bus_write(2'd2, VEC[k][15:8]);
            t0 = cyc;
            wait_irq(t0, len);
            check("R2 length", len, 8 * div);
            check("R8 irq with all enables", irq, 1);
            bus_read(2'd1, rd); check("R4 completion flag", rd, 8'h80);
            bus_read(2'd2, rd); check("R4 received byte", rd, VEC[k][7:0]);
            check("R3 MSB-first mosi", cap, VEC[k][15:8]);
            bus_read(2'd1, rd); check("R7 marked flag cleared", rd, 8'h00);
            check("R3 sck idle", sck, 0);
        end

        // R2 rate latched at start
        bus_write(2'd0, 8'hC0);
        load_slave(8'h55);
        bus_write(2'd2, 8'h33);
        t0 = cyc;
        bus_write(2'd0, 8'hC3);
        wait_irq(t0, len);
        check("R2 rate sampled at start", len, 32);
        bus_read(2'd1, rd); bus_read(2'd2, rd);
        check("R2 byte after rate change", rd, 8'h55);

        // R6 collision during exchange
        bus_write(2'd0, 8'hC0);
        load_slave(8'h69);
        bus_write(2'd2, 8'h96);
        repeat (4) @(posedge clk);
        bus_write(2'd2, 8'h00);
        bus_read(2'd1, rd); check("R6 collision flag", rd, 8'h40);
        wait_irq(cyc, len);
        bus_read(2'd2, rd); check("R6 received byte intact", rd, 8'h69);
        check("R6 sent byte intact", cap, 8'h96);
        bus_read(2'd1, rd); check("R7 only marked flag cleared", rd, 8'h80);
        bus_read(2'd2, rd);
        bus_read(2'd1, rd); check("R7 cleared after second step", rd, 8'h00);

        // R8 gating, R7 unmarked access, R9 acknowledge
        bus_write(2'd0, 8'h40);
        load_slave(8'hF0);
        bus_write(2'd2, 8'h0F);
        repeat (40) @(posedge clk);
        #1 check("R8 no irq without ie", irq, 0);
        bus_write(2'd0, 8'hC0); #1 check("R8 irq when ie set", irq, 1);
        bus_write(2'd0, 8'h80); #1 check("R8 no irq without enable", irq, 0);
        bus_write(2'd0, 8'hC0);
        bus_read(2'd2, rd); check("R4 data via gating run", rd, 8'hF0);
        #1 check("R7 unmarked access keeps flag", irq, 1);
        @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
        check("R9 ack drops irq", irq, 0);
        bus_read(2'd1, rd); check("R9 flag cleared by ack", rd, 8'h00);

        // R5 write with enable clear
        bus_read(2'd2, saved);
        bus_write(2'd0, 8'h80);
        bus_write(2'd2, 8'hA5);
        sck_seen = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (sck) sck_seen = 1; end
        check("R5 no serial clock", sck_seen, 0);
        bus_read(2'd2, rd); check("R5 data unchanged", rd, saved);
        bus_read(2'd1, rd); check("R5 no flags", rd, 8'h00);

        summary();
    end
endmodule